// File: doc/BRIEF.md
# Program Window Bank Mapper

This block turns a CPU address in the upper half of a 16-bit address space into a physical bank choice for external program storage. The range 0x8000–0xFFFF is treated as four 8 KB slots, and a small 0x6000–0x7FFF window is always backed by work RAM. For each access the block reports whether the address falls in a mapped window. It also gives the ROM/RAM choice, the physical 8 KB bank index, the in-bank offset, and a work-RAM write strobe. The memories sit outside the block.

Software sets up the mapping through a register-write port. One layout register picks how the four slots are grouped:

- one 32 KB bank,
- two 16 KB banks,
- a 16 KB bank followed by two 8 KB banks,
- four 8 KB banks.

Per-slot bank registers hold the bank numbers, and bit 7 of a bank register marks the bank as ROM (1) or RAM (0). Two lock registers must hold a fixed pair of values before any RAM write is let through. The address decode is purely combinational. Register writes land on the next rising clock edge.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the layout is 3, every slot bank register holds 0xFF, both lock registers and the work-RAM bank register hold 0. With the default 64 ROM banks, every upper slot therefore maps to ROM bank 63.
- R2: With `reg_we` high at a rising edge, `reg_sel` picks the target register, which changes from the next edge: 0 = layout (low 2 bits of data), 1 = lock A, 2 = lock B, 3 = work-RAM bank, 4..7 = slot bank registers 0..3. Selects 8..15 change nothing.
- R3: Layout 0: all four slots are ROM, and the index is bank register 3 bits 6:2 times 4 plus the slot number (address bits 14:13).
- R4: Layout 1: slots 0–1 take ROM/RAM from register 1 bit 7 and index {reg1[6:1], slot bit 0}. Slots 2–3 are ROM with index {reg3[6:1], slot bit 0}.
- R5: Layout 2: slots 0–1 behave as in layout 1. Slot 2 takes ROM/RAM from register 2 bit 7 and index reg2[6:0]. Slot 3 is ROM with index reg3[6:0].
- R6: Layout 3: slots 0–2 each use their own register, with bit 7 as ROM/RAM and bits 6:0 as the index. Slot 3 is always ROM with index reg3[6:0], whatever its bit 7 holds.
- R7: A ROM index is reduced modulo ROM_BANKS, a power of two. A RAM index keeps only its low 3 bits.
- R8: `ram_we` can be high only while lock A bits 1:0 equal 2 and lock B bits 1:0 equal 1. The upper lock bits do not matter.
- R9: A CPU write to a ROM-mapped slot, or a cycle with `cpu_wr` low, never raises `ram_we`.
- R10: Addresses 0x6000–0x7FFF map to RAM bank = work-RAM bank register bits 2:0, under the same lock rule.
- R11: Outside both windows, `win_hit`, `rom_sel`, `bank_idx` and `ram_we` are all 0.
- R12: `win_off` always carries address bits 12:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write cycle |
| win_hit | output | 1 | Address lies in a mapped window |
| rom_sel | output | 1 | 1 = ROM, 0 = RAM |
| bank_idx | output | 7 | Physical 8 KB bank index |
| win_off | output | 13 | Offset inside the 8 KB bank |
| ram_we | output | 1 | Work-RAM write enable |

## Verification
The decode outputs follow `cpu_addr` and `cpu_wr` within the same cycle. A register write becomes visible only after the rising edge on which `reg_we` is sampled. The bench changes inputs on the falling edge and reads outputs one time unit later. It holds every register write across exactly one rising edge before probing any address.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int ROM_BANKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  output logic        win_hit,
  output logic        rom_sel,
  output logic [6:0]  bank_idx,
  output logic [12:0] win_off,
  output logic        ram_we
);

  localparam int IDX_W = 7;
  localparam logic [IDX_W-1:0] ROM_MASK = IDX_W'(ROM_BANKS - 1);

  logic [1:0]       layout;
  logic [1:0]       lock_a, lock_b;
  logic [2:0]       wram_bank;
  logic [7:0]       bank0, bank1, bank2;
  logic [6:0]       bank3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      layout    <= 2'd3;
      lock_a    <= 2'd0;
      lock_b    <= 2'd0;
      wram_bank <= 3'd0;
      bank0     <= 8'hFF;
      bank1     <= 8'hFF;
      bank2     <= 8'hFF;
      bank3     <= 7'h7F;
    end else if (reg_we) begin
      case (reg_sel)
        4'd0: layout    <= reg_wdata[1:0];
        4'd1: lock_a    <= reg_wdata[1:0];
        4'd2: lock_b    <= reg_wdata[1:0];
        4'd3: wram_bank <= reg_wdata[2:0];
        4'd4: bank0     <= reg_wdata;
        4'd5: bank1     <= reg_wdata;
        4'd6: bank2     <= reg_wdata;
        4'd7: bank3     <= reg_wdata[6:0];
        default: ;
      endcase
    end
  end

  logic [1:0]       slot;
  logic             in_prg, in_wram, is_rom, unlocked;
  logic [IDX_W-1:0] raw;

  assign slot    = cpu_addr[14:13];
  assign in_prg  = cpu_addr[15];
  assign in_wram = (cpu_addr[15:13] == 3'b011);

  always_comb begin
    is_rom = 1'b1;
    raw    = bank3;
    case (layout)
      2'd0: raw = {bank3[6:2], slot};
      2'd1: begin
        if (!slot[1]) begin
          is_rom = bank1[7];
          raw    = {bank1[6:1], slot[0]};
        end else begin
          raw = {bank3[6:1], slot[0]};
        end
      end
      2'd2: begin
        case (slot)
          2'd0, 2'd1: begin
            is_rom = bank1[7];
            raw    = {bank1[6:1], slot[0]};
          end
          2'd2: begin
            is_rom = bank2[7];
            raw    = bank2[6:0];
          end
          default: raw = bank3;
        endcase
      end
      default: begin
        case (slot)
          2'd0: begin is_rom = bank0[7]; raw = bank0[6:0]; end
          2'd1: begin is_rom = bank1[7]; raw = bank1[6:0]; end
          2'd2: begin is_rom = bank2[7]; raw = bank2[6:0]; end
          default: raw = bank3;
        endcase
      end
    endcase
  end

  always_comb begin
    rom_sel  = 1'b0;
    bank_idx = '0;
    if (in_prg) begin
      rom_sel  = is_rom;
      bank_idx = is_rom ? (raw & ROM_MASK) : {4'd0, raw[2:0]};
    end else if (in_wram) begin
      bank_idx = {4'd0, wram_bank};
    end
  end

  assign unlocked = (lock_a == 2'd2) && (lock_b == 2'd1);
  assign win_hit  = in_prg | in_wram;
  assign win_off  = cpu_addr[12:0];
  assign ram_we   = cpu_wr & win_hit & ~rom_sel & unlocked;

  a_r2_layout_update: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 4'd0) |=> (layout == $past(reg_wdata[1:0])));

  a_r3_layout0_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prg && layout == 2'd0) |-> rom_sel);

  a_r6_top_slot_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> rom_sel);

  a_r8_we_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (lock_a == 2'd2 && lock_b == 2'd1));

  a_r9_we_only_ram: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && !rom_sel && win_hit));

  a_r10_wram_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_wram |-> (!rom_sel && bank_idx < 7'd8));

  a_r11_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (!rom_sel && !ram_we && bank_idx == 7'd0));

endmodule

// File: tb/prg_bank_mapper_test.sv
module prg_bank_mapper_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        win_hit, rom_sel, ram_we;
  logic [6:0]  bank_idx;
  logic [12:0] win_off;

  int checks = 0;
  int errors = 0;

  prg_bank_mapper #(.ROM_BANKS(64)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .win_hit(win_hit), .rom_sel(rom_sel), .bank_idx(bank_idx),
    .win_off(win_off), .ram_we(ram_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr_reg(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic w, input logic ehit,
                       input logic erom, input logic [6:0] eidx, input logic ewe,
                       input string tag);
    cpu_addr = a; cpu_wr = w;
    #1;
    checks++;
    if (win_hit !== ehit || rom_sel !== erom || bank_idx !== eidx ||
        ram_we !== ewe || win_off !== a[12:0]) begin
      errors++;
      $display("FAIL %s addr=%h actual hit=%b rom=%b idx=%0d we=%b off=%h expected hit=%b rom=%b idx=%0d we=%b off=%h",
               tag, a, win_hit, rom_sel, bank_idx, ram_we, win_off,
               ehit, erom, eidx, ewe, a[12:0]);
    end
  endtask

  task automatic t_reset;
    probe(16'h8000, 1'b0, 1'b1, 1'b1, 7'd63, 1'b0, "R1 slot0");
    probe(16'hA123, 1'b0, 1'b1, 1'b1, 7'd63, 1'b0, "R1 slot1 R12");
    probe(16'hC000, 1'b1, 1'b1, 1'b1, 7'd63, 1'b0, "R1 slot2");
    probe(16'hFFFF, 1'b1, 1'b1, 1'b1, 7'd63, 1'b0, "R1 slot3");
    probe(16'h6000, 1'b1, 1'b1, 1'b0, 7'd0, 1'b0, "R1 wram locked");
  endtask

  task automatic t_layout0;
    wr_reg(4'd0, 8'h04);
    wr_reg(4'd7, 8'h8D);
    wr_reg(4'd5, 8'h00);
    probe(16'h8000, 1'b0, 1'b1, 1'b1, 7'd12, 1'b0, "R3 R2 slot0");
    probe(16'hA000, 1'b0, 1'b1, 1'b1, 7'd13, 1'b0, "R3 slot1");
    probe(16'hC000, 1'b0, 1'b1, 1'b1, 7'd14, 1'b0, "R3 slot2");
    probe(16'hE000, 1'b0, 1'b1, 1'b1, 7'd15, 1'b0, "R3 slot3");
    wr_reg(4'd15, 8'h03);
    probe(16'h8000, 1'b0, 1'b1, 1'b1, 7'd12, 1'b0, "R2 unused select");
  endtask

  task automatic t_layout1;
    wr_reg(4'd0, 8'h01);
    wr_reg(4'd5, 8'h05);
    wr_reg(4'd7, 8'h93);
    probe(16'h8000, 1'b0, 1'b1, 1'b0, 7'd4, 1'b0, "R4 slot0 ram");
    probe(16'hA000, 1'b0, 1'b1, 1'b0, 7'd5, 1'b0, "R4 slot1 ram");
    probe(16'hC000, 1'b0, 1'b1, 1'b1, 7'd18, 1'b0, "R4 slot2");
    probe(16'hE000, 1'b0, 1'b1, 1'b1, 7'd19, 1'b0, "R4 slot3");
  endtask

  task automatic t_layout2;
    wr_reg(4'd0, 8'h02);
    wr_reg(4'd5, 8'h8A);
    wr_reg(4'd6, 8'h06);
    wr_reg(4'd7, 8'h21);
    probe(16'h8000, 1'b0, 1'b1, 1'b1, 7'd10, 1'b0, "R5 slot0");
    probe(16'hA000, 1'b0, 1'b1, 1'b1, 7'd11, 1'b0, "R5 slot1");
    probe(16'hC000, 1'b0, 1'b1, 1'b0, 7'd6, 1'b0, "R5 slot2 ram");
    probe(16'hE000, 1'b0, 1'b1, 1'b1, 7'd33, 1'b0, "R5 slot3");
  endtask

  task automatic t_layout3;
    wr_reg(4'd0, 8'h03);
    wr_reg(4'd4, 8'hC5);
    wr_reg(4'd5, 8'h0B);
    wr_reg(4'd6, 8'h81);
    wr_reg(4'd7, 8'h7F);
    probe(16'h8000, 1'b0, 1'b1, 1'b1, 7'd5, 1'b0, "R6 R7 rom wrap");
    probe(16'hA000, 1'b0, 1'b1, 1'b0, 7'd3, 1'b0, "R6 R7 ram low bits");
    probe(16'hC000, 1'b0, 1'b1, 1'b1, 7'd1, 1'b0, "R6 slot2");
    probe(16'hE000, 1'b0, 1'b1, 1'b1, 7'd63, 1'b0, "R6 slot3 forced rom");
  endtask

  task automatic t_lock;
    probe(16'hA000, 1'b1, 1'b1, 1'b0, 7'd3, 1'b0, "R8 both locked");
    wr_reg(4'd1, 8'h02);
    probe(16'hA000, 1'b1, 1'b1, 1'b0, 7'd3, 1'b0, "R8 only A");
    wr_reg(4'd2, 8'h01);
    probe(16'hA000, 1'b1, 1'b1, 1'b0, 7'd3, 1'b1, "R8 unlocked");
    wr_reg(4'd1, 8'hF6);
    probe(16'hA000, 1'b1, 1'b1, 1'b0, 7'd3, 1'b1, "R8 upper bits ignored");
    wr_reg(4'd1, 8'h03);
    probe(16'hA000, 1'b1, 1'b1, 1'b0, 7'd3, 1'b0, "R8 relocked");
    wr_reg(4'd1, 8'h02);
  endtask

  task automatic t_rom_write;
    probe(16'h8000, 1'b1, 1'b1, 1'b1, 7'd5, 1'b0, "R9 write to rom");
    probe(16'hE000, 1'b1, 1'b1, 1'b1, 7'd63, 1'b0, "R9 write to slot3");
    probe(16'hA000, 1'b0, 1'b1, 1'b0, 7'd3, 1'b0, "R9 read of ram");
  endtask

  task automatic t_wram;
    wr_reg(4'd3, 8'h0D);
    probe(16'h6000, 1'b1, 1'b1, 1'b0, 7'd5, 1'b1, "R10 low edge");
    probe(16'h7FFF, 1'b1, 1'b1, 1'b0, 7'd5, 1'b1, "R10 high edge R12");
    wr_reg(4'd2, 8'h00);
    probe(16'h7000, 1'b1, 1'b1, 1'b0, 7'd5, 1'b0, "R10 locked");
  endtask

  task automatic t_outside;
    probe(16'h5FFF, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, "R11 below wram");
    probe(16'h0000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, "R11 zero");
    probe(16'h4020, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, "R11 mid");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout0();
    t_layout1();
    t_layout2();
    t_layout3();
    t_lock();
    t_rom_write();
    t_wram();
    t_outside();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule